// File: doc/BRIEF.md
# Product-Term Array with Inverted-OR Feedback

This block evaluates a small programmable AND-OR plane for sequencer logic. Its literals are a vector of signal inputs. These are typically device inputs concatenated with register feedback. Each product term picks any literal in true form, in inverted form, or not at all, through two configuration masks. Per-output selection masks then OR chosen product terms into the sum outputs. A sum can serve as the D input, or as a J or K input, of a downstream register.

One extra term gives the plane an inverted-OR over a chosen set of product terms. When none of those terms is active, this complement signal goes high. It feeds back into the AND plane as one more literal, so a single product term can fire on "no defined state is active" without listing every illegal state. A term that is connected to the complement OR and also reads the complement literal would form a loop. The block does not evaluate such a term. It forces the term inactive and raises an error flag.

All outputs are registered once, so every result appears one clock after the inputs and masks that produced it. Inside one cycle the complement path is two passes through the plane: first the inverted-OR, then the terms that read it.

Top module: `pla_cmp_array`

## Requirements
- R1: While `rst_n` is low at a rising edge, `term_o`, `sum_o`, `cmp_o` and `loop_err_o` are all 0 after that edge.
- R2: Product term p is active only when every literal it selects matches. A literal with bit i set in the true mask (bit p*N_IN+i of `pt_true_i`) needs `lit_i[i]`=1. A literal with bit i set in the inverted mask (`pt_comp_i`) needs `lit_i[i]`=0. `pt_ctrue_i[p]` requires the complement signal to be 1, and `pt_ccomp_i[p]` requires it to be 0.
- R3: A product term that selects no literal at all, including the complement literal, is inactive.
- R4: A product term that selects both forms of the same literal is inactive whatever the inputs. This includes `pt_ctrue_i[p]` and `pt_ccomp_i[p]` both set.
- R5: The complement signal is 0 when any product term p with `cmp_sel_i[p]`=1 is active, and 1 otherwise. It is 1 when no term is connected.
- R6: Within one cycle the complement signal is available to product terms as a literal. A term selecting only its true form follows it, and a term selecting only its inverted form follows its inverse.
- R7: Sum output k is the OR of the product terms p with bit k*N_PT+p of `or_sel_i` set.
- R8: A product term with `cmp_sel_i[p]`=1 that also selects either form of the complement literal is forced inactive. It is left out of the complement OR, and `loop_err_o` is 1 for that cycle.
- R9: All four outputs are registered. They change only at a rising edge and reflect the inputs present before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lit_i | input | N_IN | Input and feedback literals |
| pt_true_i | input | N_PT*N_IN | Per term, literals used in true form |
| pt_comp_i | input | N_PT*N_IN | Per term, literals used in inverted form |
| pt_ctrue_i | input | N_PT | Per term, complement literal in true form |
| pt_ccomp_i | input | N_PT | Per term, complement literal in inverted form |
| cmp_sel_i | input | N_PT | Terms connected to the complement OR |
| or_sel_i | input | N_SUM*N_PT | Per sum, selected product terms |
| term_o | output | N_PT | Registered product term values |
| sum_o | output | N_SUM | Registered sum outputs |
| cmp_o | output | 1 | Registered complement signal |
| loop_err_o | output | 1 | Registered loop error flag |

## Verification
The assertions assume that the masks and literals are settled before the rising edge that samples them, and that a looping configuration is legal input which only raises the flag. The stimulus changes every input on the falling edge only. It covers directed configurations for each rule. It then covers a long sparse random phase in which looping terms, conflicting masks and empty terms all occur with fair probability, so that each guarded implication is actually triggered.

// File: rtl/pla_pkg.sv
// Shared types for the product-term array.
// Assumes nothing beyond IEEE 1800-2017 packed structs.
package pla_pkg;
    // Upper bound on product terms that one sum may combine
    localparam int MAX_TERMS_PER_SUM = 64;

    // Qualifiers that decide whether a term may be active at all
    typedef struct packed {
        logic looped;   // term feeds the complement OR and reads it
        logic clash;    // both forms of one literal selected
        logic empty;    // no literal selected
    } term_flags_t;
endpackage

// File: rtl/pla_term.sv
// One product term: AND of selected literals plus the complement literal.
// Assumes masks are static within a cycle; clk and rst_n only serve the checks.
module pla_term #(
    parameter int N_IN = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_IN-1:0] lit_i,
    input  logic [N_IN-1:0] true_m,
    input  logic [N_IN-1:0] comp_m,
    input  logic            ctrue_i,
    input  logic            ccomp_i,
    input  logic            cmp_sel_i,
    input  logic            cmp_i,
    output logic            base_ok_o,
    output logic            loop_o,
    output logic            term_o
);
    import pla_pkg::*;

    term_flags_t flags;
    logic        lits_met;
    logic        uses_cmp;

    // Classify the term configuration
    always_comb begin
        uses_cmp     = ctrue_i | ccomp_i;
        flags.looped = cmp_sel_i & uses_cmp;
        flags.clash  = (|(true_m & comp_m)) | (ctrue_i & ccomp_i);
        flags.empty  = ~(|true_m) & ~(|comp_m) & ~uses_cmp;
    end

    // Match the ordinary literals in their selected forms
    always_comb begin
        lits_met = ((lit_i & true_m) == true_m) && ((~lit_i & comp_m) == comp_m);
    end

    // Literal-only result for the complement OR, then the full term
    always_comb begin
        base_ok_o = lits_met & ~flags.clash & ~flags.empty;
        loop_o    = flags.looped;
        term_o    = base_ok_o & ~flags.looped
                    & (~ctrue_i | cmp_i) & (~ccomp_i | ~cmp_i);
    end

    a_r4_clash_inactive: assert property (@(posedge clk) disable iff (!rst_n)
        (|(true_m & comp_m)) |-> !term_o);
    a_r3_empty_inactive: assert property (@(posedge clk) disable iff (!rst_n)
        (true_m == '0 && comp_m == '0 && !ctrue_i && !ccomp_i) |-> !term_o);
    a_r6_follows_cmp: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrue_i && term_o) |-> cmp_i);
    a_r8_loop_inactive: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_sel_i && (ctrue_i || ccomp_i)) |-> !term_o);
endmodule

// File: rtl/pla_nor.sv
// Inverted OR over the connected, non-looping product terms.
// Assumes base_ok_i does not depend on the output (loops are excluded).
module pla_nor #(
    parameter int N_PT = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_PT-1:0] base_ok_i,
    input  logic [N_PT-1:0] loop_i,
    input  logic [N_PT-1:0] sel_i,
    output logic            cmp_o
);
    // Complement is high only when no eligible connected term is active
    always_comb begin
        cmp_o = ~(|(sel_i & base_ok_i & ~loop_i));
    end

    a_r5_any_active_low: assert property (@(posedge clk) disable iff (!rst_n)
        (|(sel_i & base_ok_i & ~loop_i)) |-> !cmp_o);
    a_r5_none_sel_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == '0) |-> cmp_o);
endmodule

// File: rtl/pla_or.sv
// Programmable OR plane: each sum combines a selected set of product terms.
// Assumes N_PT stays within the per-sum term limit.
module pla_or #(
    parameter int N_PT  = 8,
    parameter int N_SUM = 3
) (
    input  logic [N_PT-1:0]       term_i,
    input  logic [N_SUM*N_PT-1:0] sel_i,
    output logic [N_SUM-1:0]      sum_o
);
    for (genvar k = 0; k < N_SUM; k++) begin : g_sum
        // One sum: OR of its selected terms
        always_comb begin
            sum_o[k] = |(sel_i[k*N_PT +: N_PT] & term_i);
        end
    end
endmodule

// File: rtl/pla_cmp_array.sv
// Top: product-term array with inverted-OR complement feedback and
// registered outputs. Assumes inputs settle before each rising edge.
module pla_cmp_array #(
    parameter int N_IN  = 6,
    parameter int N_PT  = 8,
    parameter int N_SUM = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_IN-1:0]        lit_i,
    input  logic [N_PT*N_IN-1:0]   pt_true_i,
    input  logic [N_PT*N_IN-1:0]   pt_comp_i,
    input  logic [N_PT-1:0]        pt_ctrue_i,
    input  logic [N_PT-1:0]        pt_ccomp_i,
    input  logic [N_PT-1:0]        cmp_sel_i,
    input  logic [N_SUM*N_PT-1:0]  or_sel_i,
    output logic [N_PT-1:0]        term_o,
    output logic [N_SUM-1:0]       sum_o,
    output logic                   cmp_o,
    output logic                   loop_err_o
);
    localparam int TERM_LIMIT = pla_pkg::MAX_TERMS_PER_SUM;

    logic [N_PT-1:0]  base_ok;
    logic [N_PT-1:0]  loop_c;
    logic [N_PT-1:0]  term_c;
    logic [N_SUM-1:0] sum_c;
    logic             cmp_c;

    initial begin
        if (N_PT > TERM_LIMIT) $error("N_PT exceeds per-sum term limit");
    end

    for (genvar p = 0; p < N_PT; p++) begin : g_term
        pla_term #(.N_IN(N_IN)) u_term (
            .clk       (clk),
            .rst_n     (rst_n),
            .lit_i     (lit_i),
            .true_m    (pt_true_i[p*N_IN +: N_IN]),
            .comp_m    (pt_comp_i[p*N_IN +: N_IN]),
            .ctrue_i   (pt_ctrue_i[p]),
            .ccomp_i   (pt_ccomp_i[p]),
            .cmp_sel_i (cmp_sel_i[p]),
            .cmp_i     (cmp_c),
            .base_ok_o (base_ok[p]),
            .loop_o    (loop_c[p]),
            .term_o    (term_c[p])
        );
    end

    pla_nor #(.N_PT(N_PT)) u_nor (
        .clk       (clk),
        .rst_n     (rst_n),
        .base_ok_i (base_ok),
        .loop_i    (loop_c),
        .sel_i     (cmp_sel_i),
        .cmp_o     (cmp_c)
    );

    pla_or #(.N_PT(N_PT), .N_SUM(N_SUM)) u_or (
        .term_i (term_c),
        .sel_i  (or_sel_i),
        .sum_o  (sum_c)
    );

    // Output register stage with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            term_o     <= '0;
            sum_o      <= '0;
            cmp_o      <= 1'b0;
            loop_err_o <= 1'b0;
        end else begin
            term_o     <= term_c;
            sum_o      <= sum_c;
            cmp_o      <= cmp_c;
            loop_err_o <= |loop_c;
        end
    end

    for (genvar k = 0; k < N_SUM; k++) begin : g_chk
        a_r7_sum_needs_term: assert property (@(posedge clk) disable iff (!rst_n)
            sum_o[k] |-> $past(|(or_sel_i[k*N_PT +: N_PT] & term_c)));
    end
    a_r8_loop_flag: assert property (@(posedge clk) disable iff (!rst_n)
        loop_err_o |-> $past(|(cmp_sel_i & (pt_ctrue_i | pt_ccomp_i))));
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (term_o == '0 && sum_o == '0 && !cmp_o && !loop_err_o));
endmodule

// File: tb/tb_pla_cmp_array.sv
module tb_pla_cmp_array;
    localparam int CLK_PERIOD = 10;
    localparam int N_IN  = 6;
    localparam int N_PT  = 8;
    localparam int N_SUM = 3;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [N_IN-1:0]       lit = '0;
    logic [N_PT*N_IN-1:0]  pt_t = '0;
    logic [N_PT*N_IN-1:0]  pt_c = '0;
    logic [N_PT-1:0]       ct = '0;
    logic [N_PT-1:0]       cc = '0;
    logic [N_PT-1:0]       csel = '0;
    logic [N_SUM*N_PT-1:0] osel = '0;
    logic [N_PT-1:0]       term_o;
    logic [N_SUM-1:0]      sum_o;
    logic                  cmp_o;
    logic                  loop_err_o;

    int checks = 0;
    int errors = 0;
    // expected registered outputs: {loop, cmp, sums, terms}
    logic [N_PT+N_SUM+1:0] exp_now = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pla_cmp_array #(.N_IN(N_IN), .N_PT(N_PT), .N_SUM(N_SUM)) dut (
        .clk(clk), .rst_n(rst_n), .lit_i(lit), .pt_true_i(pt_t), .pt_comp_i(pt_c),
        .pt_ctrue_i(ct), .pt_ccomp_i(cc), .cmp_sel_i(csel), .or_sel_i(osel),
        .term_o(term_o), .sum_o(sum_o), .cmp_o(cmp_o), .loop_err_o(loop_err_o)
    );

    // Behavioural reference: evaluate the array from the requirement rules
    function automatic logic [N_PT+N_SUM+1:0] model();
        bit cmpv = 1;
        bit lp = 0;
        bit [N_PT-1:0] tv;
        bit [N_SUM-1:0] sv;
        bit ok [N_PT];
        for (int p = 0; p < N_PT; p++) begin
            bit any = ct[p] || cc[p];
            bit bad = ct[p] && cc[p];
            bit met = 1;
            for (int i = 0; i < N_IN; i++) begin
                bit wt = pt_t[p*N_IN+i];
                bit wc = pt_c[p*N_IN+i];
                if (wt || wc) any = 1;
                if (wt && wc) bad = 1;
                if (wt && !lit[i]) met = 0;
                if (wc && lit[i]) met = 0;
            end
            ok[p] = any && !bad && met;
            if (csel[p] && (ct[p] || cc[p])) lp = 1;
            else if (csel[p] && ok[p]) cmpv = 0;
        end
        for (int p = 0; p < N_PT; p++) begin
            bit loopd = csel[p] && (ct[p] || cc[p]);
            tv[p] = ok[p] && !loopd && (!ct[p] || cmpv) && (!cc[p] || !cmpv);
        end
        for (int k = 0; k < N_SUM; k++) begin
            sv[k] = 0;
            for (int p = 0; p < N_PT; p++)
                if (osel[k*N_PT+p] && tv[p]) sv[k] = 1;
        end
        return {lp, cmpv, sv, tv};
    endfunction

    task automatic compare(input string tag, input logic [N_PT+N_SUM+1:0] exp);
        logic [N_PT+N_SUM+1:0] act = {loop_err_o, cmp_o, sum_o, term_o};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Inputs are set at a falling edge; check hold before the edge, then result after
    task automatic step(input string tag);
        logic [N_PT+N_SUM+1:0] nxt = model();
        #1;
        compare("R9 hold before edge", exp_now);
        @(posedge clk);
        @(negedge clk);
        exp_now = nxt;
        compare(tag, exp_now);
    endtask

    task automatic clear_cfg();
        pt_t = '0; pt_c = '0; ct = '0; cc = '0; csel = '0; osel = '0; lit = '0;
    endtask

    initial begin
        #(CLK_PERIOD*100000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset clears outputs even with an active configuration
        @(negedge clk);
        pt_t[0] = 1'b1; lit = 6'h01; osel[0] = 1'b1;
        @(posedge clk); @(negedge clk);
        compare("R1 reset state", '0);
        rst_n = 1'b1;
        clear_cfg();
        step("R3 empty array");               // all terms empty, cmp high (R5)

        // R2: term0 = lit0 & ~lit1 into sum0
        pt_t[0] = 1'b1; pt_c[1] = 1'b1; osel[0] = 1'b1;
        lit = 6'b000001; step("R2 literals match");
        lit = 6'b000011; step("R2 inverted literal mismatch");
        lit = 6'b000000; step("R2 true literal mismatch");

        // R4: term1 selects both forms of lit2
        pt_t[N_IN+2] = 1'b1; pt_c[N_IN+2] = 1'b1; osel[N_PT+1] = 1'b1;
        lit = 6'b000100; step("R4 clash inactive");
        lit = 6'b000000; step("R4 clash inactive other value");
        ct[3] = 1'b1; cc[3] = 1'b1; osel[2*N_PT+3] = 1'b1;
        step("R4 complement literal clash");

        // R5/R6: term0 connected; term2 reads cmp true, term4 reads it inverted
        clear_cfg();
        pt_t[0] = 1'b1; csel[0] = 1'b1;
        ct[2] = 1'b1; cc[4] = 1'b1;
        osel[2] = 1'b1; osel[N_PT+4] = 1'b1;
        lit = 6'b000000; step("R5 no connected term active cmp high R6");
        lit = 6'b000001; step("R5 connected term active cmp low R6");
        pt_c[N_IN+5] = 1'b1; csel[1] = 1'b1;
        lit = 6'b100000; step("R5 two connected none active");
        lit = 6'b000000; step("R5 second connected term active");

        // R8: term0 connected and reading the complement literal
        clear_cfg();
        pt_t[0] = 1'b1; csel[0] = 1'b1; ct[0] = 1'b1; osel[0] = 1'b1;
        lit = 6'b000001; step("R8 loop flagged and term forced off");
        cc[0] = 1'b0; ct[0] = 1'b0; step("R8 loop cleared");
        cc[5] = 1'b1; csel[5] = 1'b1; step("R8 inverted form loop");

        // R7: random sparse configurations through the OR plane
        for (int n = 0; n < 400; n++) begin
            lit  = N_IN'($urandom);
            pt_t = (N_PT*N_IN)'({$urandom, $urandom} & {$urandom, $urandom});
            pt_c = (N_PT*N_IN)'({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom});
            ct   = N_PT'($urandom & $urandom);
            cc   = N_PT'($urandom & $urandom & $urandom);
            csel = N_PT'($urandom);
            osel = (N_SUM*N_PT)'($urandom);
            step("R7 random sums");
        end

        // R1: reset again mid-run
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        compare("R1 reset mid-run", '0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule